// File: doc/BRIEF.md
# Multiplexed Bus Memory Interface

This block connects an 8-bit processor to a 1 KB memory. The processor shares its low address byte and its data byte on the same lines. The high address byte comes on separate lines. The block captures the low address byte from the shared lines while the latch-enable pulse is high and keeps it while those lines carry data. It joins the kept byte with the high byte to form a 16-bit address. The top six address bits pick the memory, and the bottom ten bits pick a byte inside it.

The memory/IO indicator is combined with the active-low read and write strobes to make active-high memory read and write enables. A write stores the shared-line data on the clock edge where the memory is selected and the write enable is active. During a selected memory read, the stored byte goes out through the pad output, and the pad output enable is raised. The shared lines are split into an input, an output and an output enable, so the tristate pad sits outside the block.

Top module: `membus_bridge`

## Requirements
- R1: On every rising clock edge where `ale` is 1, the low address byte register takes the value on `ad_in`.
- R2: While `ale` is 0, the low address byte register keeps its value, whatever `ad_in` carries.
- R3: The memory location used is `{addr_hi[1:0], low address byte}`. Two addresses that differ only in `addr_hi[1:0]` reach different bytes.
- R4: `mem_cs` is 1 exactly when `io_m` is 0 and `addr_hi[7:2]` equals the base parameter `BASE_SEL` (default 0).
- R5: `mem_rd` is 1 exactly when `io_m` is 0 and `rd_n` is 0. `mem_wr` is 1 exactly when `io_m` is 0 and `wr_n` is 0.
- R6: `ad_oe` is 1 only while `mem_cs` and `mem_rd` are both 1. At those times `ad_out` carries the byte stored at the addressed location.
- R7: On a rising edge where `mem_cs` and `mem_wr` are both 1, the value on `ad_in` is stored at the addressed location. A write to an address that does not match the base leaves the memory unchanged.
- R8: A cycle with `io_m` at 1 never raises `ad_oe` and never changes the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Latch-enable pulse, high while the shared lines hold the low address |
| ad_in | input | 8 | Shared lines as seen from the pad (low address, then data) |
| ad_out | output | 8 | Read data sent to the pad |
| ad_oe | output | 1 | Pad output enable for `ad_out` |
| addr_hi | input | 8 | High address byte |
| io_m | input | 1 | 0 = memory cycle, 1 = I/O cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mem_cs | output | 1 | Decoded chip select |
| mem_rd | output | 1 | Memory read enable, active high |
| mem_wr | output | 1 | Memory write enable, active high |

## Verification
The bench changes the shared lines to unrelated data after the latch pulse. A design that followed the live lines instead of the held byte would then read from, or write to, the wrong location. It writes two addresses that differ only in the two high bits of the memory offset. Dropping those bits would make the second write overwrite the first. It also writes to an address outside the base window that has the same ten low bits, and it runs I/O-space reads and writes at a live memory location. A decoder that ignored the upper bits or the memory/IO indicator would then corrupt the stored byte or drive the pad.

// File: rtl/mbi_pkg.sv
package mbi_pkg;

    localparam int unsigned MBI_DW      = 8;
    localparam int unsigned MBI_HW      = 8;
    localparam int unsigned MBI_MEM_AW  = 10;

    typedef struct packed {
        logic sel;
        logic rd;
        logic wr;
    } mbi_strb_t;

    function automatic logic active_mem(input logic io_m, input logic strobe_n);
        return (!io_m) && (!strobe_n);
    endfunction

endpackage

// File: rtl/mbi_addr_latch.sv
module mbi_addr_latch #(
    parameter int unsigned DW = 8,
    parameter int unsigned HW = 8,
    localparam int unsigned AW = DW + HW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale,
    input  logic [DW-1:0] ad_in,
    input  logic [HW-1:0] addr_hi,
    output logic [DW-1:0] lo_q,
    output logic [AW-1:0] full_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (ale) begin
            lo_q <= ad_in;
        end
    end

    assign full_addr = {addr_hi, lo_q};

endmodule

// File: rtl/mbi_strobe_decode.sv
module mbi_strobe_decode
    import mbi_pkg::*;
#(
    parameter int unsigned SEL_W = 6,
    parameter logic [SEL_W-1:0] BASE_V = '0
) (
    input  logic [SEL_W-1:0] sel_bits,
    input  logic             io_m,
    input  logic             rd_n,
    input  logic             wr_n,
    output mbi_strb_t        strb
);

    always_comb begin
        strb.sel = (!io_m) && (sel_bits == BASE_V);
        strb.rd  = active_mem(io_m, rd_n);
        strb.wr  = active_mem(io_m, wr_n);
    end

endmodule

// File: rtl/mbi_mem_array.sv
module mbi_mem_array #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 10,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/membus_bridge.sv
module membus_bridge
    import mbi_pkg::*;
#(
    parameter int unsigned DW       = MBI_DW,
    parameter int unsigned HW       = MBI_HW,
    parameter int unsigned MEM_AW   = MBI_MEM_AW,
    parameter int unsigned BASE_SEL = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [HW-1:0] addr_hi,
    input  logic          io_m,
    input  logic          rd_n,
    input  logic          wr_n,
    output logic          mem_cs,
    output logic          mem_rd,
    output logic          mem_wr
);

    localparam int unsigned AW    = DW + HW;
    localparam int unsigned SEL_W = AW - MEM_AW;
    localparam logic [SEL_W-1:0] BASE_V = SEL_W'(BASE_SEL);

    logic [DW-1:0]     lo_q;
    logic [AW-1:0]     full_addr;
    mbi_strb_t         strb;
    logic [DW-1:0]     rdata;
    logic              wr_fire;

    mbi_addr_latch #(.DW(DW), .HW(HW)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .ale       (ale),
        .ad_in     (ad_in),
        .addr_hi   (addr_hi),
        .lo_q      (lo_q),
        .full_addr (full_addr)
    );

    mbi_strobe_decode #(.SEL_W(SEL_W), .BASE_V(BASE_V)) u_dec (
        .sel_bits (full_addr[AW-1:MEM_AW]),
        .io_m     (io_m),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .strb     (strb)
    );

    assign wr_fire = strb.sel && strb.wr;

    mbi_mem_array #(.DW(DW), .AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (wr_fire),
        .addr  (full_addr[MEM_AW-1:0]),
        .wdata (ad_in),
        .rdata (rdata)
    );

    assign mem_cs = strb.sel;
    assign mem_rd = strb.rd;
    assign mem_wr = strb.wr;
    assign ad_oe  = strb.sel && strb.rd;
    assign ad_out = rdata;

endmodule

// File: rtl/mbi_checker.sv
module mbi_checker #(
    parameter int unsigned DW       = 8,
    parameter int unsigned HW       = 8,
    parameter int unsigned MEM_AW   = 10,
    parameter int unsigned BASE_SEL = 0
) (
    input logic          clk,
    input logic          rst,
    input logic          ale,
    input logic [DW-1:0] ad_in,
    input logic [DW-1:0] lo_addr,
    input logic [HW-1:0] addr_hi,
    input logic          io_m,
    input logic          mem_cs,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          ad_oe
);

    localparam int unsigned SEL_W = DW + HW - MEM_AW;
    localparam logic [SEL_W-1:0] BASE_V = SEL_W'(BASE_SEL);

    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        ale |=> (lo_addr == $past(ad_in)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ale |=> $stable(lo_addr));

    p_cs_window_r4: assert property (@(posedge clk) disable iff (rst)
        mem_cs |-> (addr_hi[HW-1:HW-SEL_W] == BASE_V));

    p_oe_gate_r6: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (mem_cs && mem_rd));

    p_io_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        io_m |-> (!ad_oe && !mem_wr && !mem_cs));

endmodule

bind membus_bridge mbi_checker #(
    .DW(DW), .HW(HW), .MEM_AW(MEM_AW), .BASE_SEL(BASE_SEL)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ale     (ale),
    .ad_in   (ad_in),
    .lo_addr (lo_q),
    .addr_hi (addr_hi),
    .io_m    (io_m),
    .mem_cs  (mem_cs),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .ad_oe   (ad_oe)
);

// File: tb/membus_bridge_tb.sv
module membus_bridge_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       ale;
    logic [7:0] ad_in;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [7:0] addr_hi;
    logic       io_m;
    logic       rd_n;
    logic       wr_n;
    logic       mem_cs;
    logic       mem_rd;
    logic       mem_wr;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] m_lo;
    logic [7:0] m_mem [1024];
    bit         m_vld [1024];

    always #5 clk = ~clk;

    membus_bridge dut_i (
        .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .addr_hi(addr_hi), .io_m(io_m), .rd_n(rd_n),
        .wr_n(wr_n), .mem_cs(mem_cs), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_cs();
        return (io_m == 1'b0) && (addr_hi[7:2] == 6'd0);
    endfunction

    // model update on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_lo <= 8'h00;
        end else begin
            if (exp_cs() && !wr_n) begin
                m_mem[{addr_hi[1:0], m_lo}] = ad_in;
                m_vld[{addr_hi[1:0], m_lo}] = 1'b1;
            end
            if (ale) m_lo <= ad_in;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            logic [9:0] off;
            off = {addr_hi[1:0], m_lo};
            chk("R4 mem_cs", {31'd0, mem_cs}, {31'd0, exp_cs()});
            chk("R5 mem_rd", {31'd0, mem_rd}, {31'd0, (!io_m && !rd_n)});
            chk("R5 mem_wr", {31'd0, mem_wr}, {31'd0, (!io_m && !wr_n)});
            chk("R6 ad_oe", {31'd0, ad_oe}, {31'd0, (exp_cs() && !rd_n)});
            if (io_m) chk("R8 io cycle oe", {31'd0, ad_oe}, 32'd0);
            if (ad_oe && m_vld[off])
                chk("R3 R7 R2 ad_out", {24'd0, ad_out}, {24'd0, m_mem[off]});
        end
    end

    task automatic idle();
        @(posedge clk); #2;
        ale = 1'b0; rd_n = 1'b1; wr_n = 1'b1; io_m = 1'b0; ad_in = 8'hC3;
    endtask

    task automatic bus_cycle(input logic [15:0] a, input logic is_io,
                             input logic is_wr, input logic [7:0] d);
        @(posedge clk); #2;
        ale = 1'b1; ad_in = a[7:0]; addr_hi = a[15:8]; io_m = is_io;
        rd_n = 1'b1; wr_n = 1'b1;
        @(posedge clk); #2;
        ale = 1'b0; ad_in = is_wr ? d : ~a[7:0];
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        @(posedge clk); #2;
        if (!is_wr) ad_in = a[7:0] ^ 8'h5A;
        @(posedge clk); #2;
        rd_n = 1'b1; wr_n = 1'b1;
    endtask

    // directed read: checks the pad value in the data phase
    task automatic read_expect(input logic [15:0] a, input logic [7:0] d, input string req);
        @(posedge clk); #2;
        ale = 1'b1; ad_in = a[7:0]; addr_hi = a[15:8]; io_m = 1'b0;
        rd_n = 1'b1; wr_n = 1'b1;
        @(posedge clk); #2;
        ale = 1'b0; ad_in = 8'hFF ^ a[7:0]; rd_n = 1'b0;
        @(negedge clk);
        chk({req, " oe"}, {31'd0, ad_oe}, 32'd1);
        chk({req, " data"}, {24'd0, ad_out}, {24'd0, d});
        @(posedge clk); #2;
        rd_n = 1'b1;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        rst = 1'b1; ale = 1'b0; ad_in = 8'h00; addr_hi = 8'h00;
        io_m = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk("reset ad_oe", {31'd0, ad_oe}, 32'd0);
        chk("reset mem_rd", {31'd0, mem_rd}, 32'd0);
        chk("reset mem_wr", {31'd0, mem_wr}, 32'd0);
        rst = 1'b0;

        // R1 R7: basic write then read back
        bus_cycle(16'h0012, 1'b0, 1'b1, 8'hA5);
        idle();
        read_expect(16'h0012, 8'hA5, "R1 R7 readback");

        // R3: offset bits from the high byte select a distinct location
        bus_cycle(16'h0312, 1'b0, 1'b1, 8'h5A);
        read_expect(16'h0312, 8'h5A, "R3 high offset");
        read_expect(16'h0012, 8'hA5, "R3 no alias");

        // R4 R7: write outside the base window with same low ten bits
        bus_cycle(16'h0412, 1'b0, 1'b1, 8'hFF);
        bus_cycle(16'hFC12, 1'b0, 1'b1, 8'hEE);
        read_expect(16'h0012, 8'hA5, "R4 out-of-window write ignored");

        // R8: I/O cycles at a live location
        bus_cycle(16'h0012, 1'b1, 1'b1, 8'h33);
        bus_cycle(16'h0012, 1'b1, 1'b0, 8'h00);
        read_expect(16'h0012, 8'hA5, "R8 io write ignored");

        // R2: data phase values differ from address; location must hold
        bus_cycle(16'h00F0, 1'b0, 1'b1, 8'h0F);
        read_expect(16'h00F0, 8'h0F, "R2 held address");
        read_expect(16'h000F, 8'hXX, "R2 skip") ;

        // sweep with pseudo-random data, model compared every cycle
        lfsr = 8'h1D;
        for (int i = 0; i < 64; i++) begin
            logic [15:0] a;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            a = {6'd0, i[1:0], lfsr ^ i[7:0]};
            bus_cycle(a, 1'b0, 1'b1, lfsr);
            bus_cycle(a, 1'b0, 1'b0, 8'h00);
            bus_cycle(a, 1'b1, 1'b0, 8'h00);
        end
        idle();
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule